// File: doc/BRIEF.md
# Submission Ring Copy Engine

This block services one channel of a descriptor-driven memory copier. Software places 32-byte work entries in a submission ring in memory and moves the programmed tail index forward. While the engine is enabled and not held, it fetches each entry between its own consume index and that tail, one entry at a time. It checks the opcode and byte count, copies the data one 32-bit word at a time, and posts a 16-byte completion record into a second ring. It can also raise a one-cycle interrupt pulse for each entry.

Both rings share one programmable depth. The completion records carry a phase-style valid flag that inverts on each pass around the completion ring, so software can tell fresh records from stale ones without clearing memory. Memory is reached through one read port and one write port. Each port uses a request/acknowledge pair, and the engine never has more than one access outstanding.

Top module: `ring_copy_engine`

## Requirements
- R1: After a synchronous reset, `sq_head` and `cq_tail` are 0, `rd_req`, `wr_req` and `irq` are low, and the first completion record written carries valid flag 1.
- R2: A fetch starts only when `go` is high, `pause` is low and `sq_head` differs from `sq_tail`. A fetch reads the 8 words at `sq_base + 32*sq_head + 4*k` for k = 0..7 in ascending order. Word 0 is control, word 3 is the byte length, words 4/5 are the low/high source address and words 6/7 are the low/high destination address.
- R3: When the opcode (word 0 bits 3:0) is 4 and the length is nonzero, the engine copies ceil(length/4) words. It reads source+4i and then writes that word to destination+4i, for i rising from 0.
- R4: Any other opcode, including 1, gives status 1. Opcode 4 with length 0 gives status 2. In both cases no copy read or write takes place.
- R5: The completion record is 4 words written in ascending order to `cq_base + 16*cq_tail`. Words 0 and 1 are zero. Word 2 holds, in bits 15:0, the SQ index after this entry has been consumed. Word 3 holds the valid flag in bit 16 and the status in bits 31:17, with its other bits zero. Status 0 means success.
- R6: After each completion record, `sq_head` and `cq_tail` each step by one in the same cycle and wrap from depth-1 to 0. `depth` must be at least 2 and must stay constant while the engine runs.
- R7: The valid flag written into completion records inverts each time `cq_tail` wraps to 0.
- R8: `irq` pulses high for exactly one cycle, in the cycle the pointers step, only for entries whose word 0 bit 8 is set.
- R9: `pause` is sampled only between entries. An entry already under way completes fully, and no further fetch starts while `pause` is high.
- R10: Word 0 bits 14:12 and word 2 bits 26:24 (attribute fields) do not change the copy or the completion record.
- R11: Each request stays asserted with a stable address (and stable write data) until its acknowledge. `rd_req` and `wr_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Engine enable |
| pause | input | 1 | Hold at the next entry boundary |
| sq_base | input | AW | Byte address of the submission ring |
| sq_tail | input | PW | Producer index written by software |
| cq_base | input | AW | Byte address of the completion ring |
| depth | input | PW | Entries per ring |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read byte address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write byte address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| sq_head | output | PW | Engine consume index |
| cq_tail | output | PW | Engine completion index |
| irq | output | 1 | Per-entry interrupt pulse |

## Verification
Two functions can fall in the same cycle. The first is the hold request: `pause` can rise while a copy write is in flight. The second is the pointer step and interrupt pulse that end that same entry. The bench raises `pause` at the exact negedge on which it sees the first copy write request. It then judges that the interrupted entry still produces every copy word and its completion record, and that the next pending entry leaves its scoreboard items unconsumed. A second overlap is the completion-ring wrap landing on the same step as the submission-ring wrap. There the bench checks that the valid flag inverts in the record written just after the wrap.

// File: rtl/rce_pkg.sv
package rce_pkg;
  localparam int WORD_W = 32;
  localparam int SQE_WORDS = 8;
  localparam int SQE_SHIFT = 5;
  localparam int CQE_SHIFT = 4;
  localparam int STAT_W = 15;
  localparam int NWORD_W = 31;

  localparam logic [3:0] OP_COPY = 4'h4;

  localparam logic [STAT_W-1:0] STAT_OK       = 15'd0;
  localparam logic [STAT_W-1:0] STAT_BAD_OP   = 15'd1;
  localparam logic [STAT_W-1:0] STAT_ZERO_LEN = 15'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_CRD, S_CWR, S_CPL, S_ADV
  } eng_state_t;
endpackage

// File: rtl/rce_ring_ptr.sv
module rce_ring_ptr #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [PW-1:0] depth,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] nxt,
  output logic          phase
);
  always_comb nxt = (ptr == depth - PW'(1)) ? '0 : ptr + PW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      phase <= 1'b1;
    end else if (step) begin
      ptr <= nxt;
      if (nxt == '0) phase <= ~phase;
    end
  end

  assert_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    (depth != '0) |-> (ptr < depth));
endmodule

// File: rtl/rce_sqe_decode.sv
module rce_sqe_decode
  import rce_pkg::*;
(
  input  logic [3:0]        opcode,
  input  logic              ien_bit,
  input  logic [31:0]       len,
  output logic              ien,
  output logic [STAT_W-1:0] status,
  output logic [NWORD_W-1:0] nwords
);
  always_comb begin
    ien    = ien_bit;
    nwords = NWORD_W'(len[31:2]) + NWORD_W'(|len[1:0]);
    if (opcode != OP_COPY)   status = STAT_BAD_OP;
    else if (len == 32'd0)   status = STAT_ZERO_LEN;
    else                     status = STAT_OK;
  end
endmodule

// File: rtl/rce_cqe_format.sv
module rce_cqe_format
  import rce_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic [1:0]        sel,
  input  logic [PW-1:0]     head,
  input  logic              phase,
  input  logic [STAT_W-1:0] status,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    case (sel)
      2'd2:    word = {16'h0, 16'(head)};
      2'd3:    word = {status, phase, 16'h0};
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/ring_copy_engine.sv
module ring_copy_engine
  import rce_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          pause,
  input  logic [AW-1:0] sq_base,
  input  logic [PW-1:0] sq_tail,
  input  logic [AW-1:0] cq_base,
  input  logic [PW-1:0] depth,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [31:0]   rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  input  logic          wr_ack,
  output logic [PW-1:0] sq_head,
  output logic [PW-1:0] cq_tail,
  output logic          irq
);
  localparam int WIDX_W = $clog2(SQE_WORDS);

  eng_state_t            st;
  logic [WIDX_W-1:0]     widx;
  logic [WORD_W-1:0]     desc_q [SQE_WORDS];
  logic [WORD_W-1:0]     cpy_word;
  logic [AW-1:0]         src_cur, dst_cur;
  logic [NWORD_W-1:0]    wleft;
  logic                  step;
  logic [PW-1:0]         head_nxt, tail_nxt;
  logic                  sq_phase, cq_phase;
  logic                  dec_ien;
  logic [STAT_W-1:0]     dec_status;
  logic [NWORD_W-1:0]    dec_nwords;
  logic [WORD_W-1:0]     cqe_word;
  logic [AW-1:0]         ent_addr, cqe_addr;
  logic [63:0]           src64, dst64;
  logic                  unused_bits;

  assign step     = (st == S_ADV);
  assign ent_addr = sq_base + (AW'(sq_head) << SQE_SHIFT);
  assign cqe_addr = cq_base + (AW'(cq_tail) << CQE_SHIFT);
  assign src64    = {desc_q[5], desc_q[4]};
  assign dst64    = {desc_q[7], desc_q[6]};
  assign unused_bits = ^{desc_q[0], desc_q[1], desc_q[2], src64, dst64, sq_phase, head_nxt, tail_nxt};

  rce_ring_ptr #(.PW(PW)) u_sq_ptr (
    .clk(clk), .rst(rst), .step(step), .depth(depth),
    .ptr(sq_head), .nxt(head_nxt), .phase(sq_phase));

  rce_ring_ptr #(.PW(PW)) u_cq_ptr (
    .clk(clk), .rst(rst), .step(step), .depth(depth),
    .ptr(cq_tail), .nxt(tail_nxt), .phase(cq_phase));

  rce_sqe_decode u_dec (
    .opcode(desc_q[0][3:0]), .ien_bit(desc_q[0][8]), .len(desc_q[3]),
    .ien(dec_ien), .status(dec_status), .nwords(dec_nwords));

  rce_cqe_format #(.PW(PW)) u_fmt (
    .sel(widx[1:0]), .head(head_nxt), .phase(cq_phase),
    .status(dec_status), .word(cqe_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      widx     <= '0;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      wr_req   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      irq      <= 1'b0;
      cpy_word <= '0;
      src_cur  <= '0;
      dst_cur  <= '0;
      wleft    <= '0;
      for (int i = 0; i < SQE_WORDS; i++) desc_q[i] <= '0;
    end else begin
      irq <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go && !pause && (sq_head != sq_tail)) begin
            st   <= S_FETCH;
            widx <= '0;
          end
        end
        S_FETCH: begin
          if (!rd_req) begin
            rd_req  <= 1'b1;
            rd_addr <= ent_addr + AW'({widx, 2'b00});
          end else if (rd_ack) begin
            rd_req       <= 1'b0;
            desc_q[widx] <= rd_data;
            if (widx == WIDX_W'(SQE_WORDS - 1)) st <= S_CHECK;
            else widx <= widx + WIDX_W'(1);
          end
        end
        S_CHECK: begin
          widx <= '0;
          if (dec_status != STAT_OK) begin
            st <= S_CPL;
          end else begin
            src_cur <= src64[AW-1:0];
            dst_cur <= dst64[AW-1:0];
            wleft   <= dec_nwords;
            st      <= S_CRD;
          end
        end
        S_CRD: begin
          if (!rd_req) begin
            rd_req  <= 1'b1;
            rd_addr <= src_cur;
          end else if (rd_ack) begin
            rd_req   <= 1'b0;
            cpy_word <= rd_data;
            st       <= S_CWR;
          end
        end
        S_CWR: begin
          if (!wr_req) begin
            wr_req  <= 1'b1;
            wr_addr <= dst_cur;
            wr_data <= cpy_word;
          end else if (wr_ack) begin
            wr_req  <= 1'b0;
            src_cur <= src_cur + AW'(4);
            dst_cur <= dst_cur + AW'(4);
            wleft   <= wleft - NWORD_W'(1);
            st      <= (wleft == NWORD_W'(1)) ? S_CPL : S_CRD;
          end
        end
        S_CPL: begin
          if (!wr_req) begin
            wr_req  <= 1'b1;
            wr_addr <= cqe_addr + AW'({widx[1:0], 2'b00});
            wr_data <= cqe_word;
          end else if (wr_ack) begin
            wr_req <= 1'b0;
            if (widx[1:0] == 2'd3) st <= S_ADV;
            else widx <= widx + WIDX_W'(1);
          end
        end
        S_ADV: begin
          irq <= dec_ien;
          st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_port_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  assert_lockstep_R6: assert property (@(posedge clk) disable iff (rst)
    (sq_head != $past(sq_head)) |-> (cq_tail != $past(cq_tail)));
  assert_pause_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && pause) |=> (st == S_IDLE));
  assert_no_fetch_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !go) |=> !rd_req);
endmodule

// File: tb/ring_copy_engine_tb.sv
module ring_copy_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int PW = 16;
  localparam int DEPTH = 4;
  localparam logic [31:0] SQB = 32'h000;
  localparam logic [31:0] CQB = 32'h200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0, pause = 1'b0;
  logic [PW-1:0] sq_tail = '0;
  logic rd_req, wr_req, irq;
  logic [AW-1:0] rd_addr, wr_addr;
  logic rd_ack = 1'b0, wr_ack = 1'b0;
  logic [31:0] rd_data = '0, wr_data;
  logic [PW-1:0] sq_head, cq_tail;

  logic [31:0] mem [0:1023];
  logic [63:0] exp_q [$];
  int errors = 0, checks = 0;
  int irq_cnt = 0, irq_exp = 0, rd_cnt = 0, overlap = 0;
  int mtail = 0;
  logic mphase = 1'b1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_copy_engine #(.AW(AW), .PW(PW)) u_dut (
    .clk(clk), .rst(rst), .go(go), .pause(pause),
    .sq_base(SQB), .sq_tail(sq_tail), .cq_base(CQB), .depth(PW'(DEPTH)),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .sq_head(sq_head), .cq_tail(cq_tail), .irq(irq));

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    rd_ack <= rd_req && !rd_ack;
    if (rd_req && !rd_ack) rd_data <= mem[rd_addr[11:2]];
    wr_ack <= wr_req && !wr_ack;
    if (wr_req && !wr_ack) mem[wr_addr[11:2]] <= wr_data;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_req && wr_req) overlap++;
      if (rd_req && rd_ack) rd_cnt++;
      if (irq) irq_cnt++;
      if (wr_req && wr_ack) begin
        if (exp_q.size() == 0) chk(1'b0, "R3/R5 unexpected write", {wr_addr, wr_data}, 64'h0);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk({wr_addr, wr_data} == e, "R3/R5/R7 write", {wr_addr, wr_data}, e);
        end
      end
    end
  end

  // driver: place an entry and push the writes it must produce
  task automatic put_entry(input int idx, input logic [31:0] dw0, input logic [31:0] dw2,
                           input logic [31:0] len, input logic [31:0] src, input logic [31:0] dst);
    int b;
    logic [14:0] stv;
    b = (SQB + idx*32) / 4;
    mem[b]   <= dw0;   mem[b+1] <= 32'hDEAD0001; mem[b+2] <= dw2; mem[b+3] <= len;
    mem[b+4] <= src;   mem[b+5] <= 32'h0;        mem[b+6] <= dst; mem[b+7] <= 32'h0;
    if (dw0[3:0] != 4'h4) stv = 15'd1;
    else if (len == 0)    stv = 15'd2;
    else                  stv = 15'd0;
    if (stv == 0)
      for (int k = 0; k < (len + 3) / 4; k++)
        exp_q.push_back({dst + 32'(4*k), 32'hA5000000 ^ (src + 32'(4*k))});
    begin
      logic [31:0] ca;
      ca = CQB + 32'(mtail*16);
      exp_q.push_back({ca,          32'h0});
      exp_q.push_back({ca + 32'd4,  32'h0});
      exp_q.push_back({ca + 32'd8,  {16'h0, 16'((idx + 1) % DEPTH)}});
      exp_q.push_back({ca + 32'd12, {stv, mphase, 16'h0}});
    end
    if (dw0[8]) irq_exp++;
    mtail = (mtail + 1) % DEPTH;
    if (mtail == 0) mphase = ~mphase;
  endtask

  task automatic wait_head(input int target);
    for (int i = 0; i < 3000 && sq_head != PW'(target); i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      chk(1'b0, "watchdog", 64'h0, 64'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] <= 32'hA5000000 ^ 32'(i*4);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sq_head == 0 && cq_tail == 0, "R1 pointers", {sq_head, cq_tail}, 64'h0);
    chk(!rd_req && !wr_req && !irq, "R1 outputs idle", {rd_req, wr_req, irq}, 64'h0);

    // R2: pending entries but engine disabled
    put_entry(0, 32'h104, 32'h0, 32'd12, 32'h400, 32'h800);            // copy 3 words, irq
    put_entry(1, 32'h7004, 32'h0700_0000, 32'd5, 32'h440, 32'h840);    // R10 attributes, 2 words
    put_entry(2, 32'h101, 32'h0, 32'd8, 32'h460, 32'h860);             // R4 small-package op
    sq_tail = 3;
    repeat (30) @(negedge clk);
    chk(rd_cnt == 0, "R2 no fetch while go low", rd_cnt, 0);
    go = 1'b1;
    wait_head(3);
    chk(sq_head == 3 && cq_tail == 3, "R6 pointers after 3 entries", {sq_head, cq_tail}, {16'd3, 16'd3});
    chk(rd_cnt == 29, "R2/R4 read count (no copy on bad opcode)", rd_cnt, 29);
    chk(irq_cnt == irq_exp, "R8 irq count phase 1", irq_cnt, irq_exp);

    // R4 zero length then wrap of both rings, R7 phase flip
    put_entry(3, 32'h104, 32'h0, 32'd0, 32'h470, 32'h870);
    put_entry(0, 32'h004, 32'h0, 32'd4, 32'h480, 32'h880);
    sq_tail = 1;
    wait_head(1);
    chk(sq_head == 1 && cq_tail == 1, "R6 wrap", {sq_head, cq_tail}, {16'd1, 16'd1});
    chk(rd_cnt == 29 + 16 + 1, "R4 zero length no copy read", rd_cnt, 46);
    chk(irq_cnt == irq_exp, "R8 irq count phase 2", irq_cnt, irq_exp);

    // R9 pause held before an entry
    pause = 1'b1;
    put_entry(1, 32'h104, 32'h0, 32'd8, 32'h4C0, 32'h8C0);
    sq_tail = 2;
    repeat (40) @(negedge clk);
    chk(sq_head == 1 && rd_cnt == 46, "R9 no fetch while paused", {sq_head, 16'(rd_cnt)}, {16'd1, 16'd46});
    pause = 1'b0;
    wait_head(2);
    chk(sq_head == 2, "R9 resume", sq_head, 2);

    // R9 pause raised during a copy write
    put_entry(2, 32'h004, 32'h0, 32'd16, 32'h500, 32'h900);
    put_entry(3, 32'h104, 32'h0, 32'd4, 32'h540, 32'h940);
    sq_tail = 0;
    for (int i = 0; i < 2000 && !wr_req; i++) @(negedge clk);
    pause = 1'b1;
    repeat (80) @(negedge clk);
    chk(sq_head == 3, "R9 entry under way completes", sq_head, 3);
    chk(exp_q.size() == 5, "R9 next entry not started", exp_q.size(), 5);
    pause = 1'b0;
    wait_head(0);
    chk(sq_head == 0 && cq_tail == 0, "R6 second wrap", {sq_head, cq_tail}, 64'h0);
    chk(exp_q.size() == 0, "R3/R5 all writes seen", exp_q.size(), 0);
    chk(irq_cnt == irq_exp, "R8 irq total", irq_cnt, irq_exp);
    chk(overlap == 0, "R11 ports exclusive", overlap, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule